// File: doc/BRIEF.md
# Core-Local Interrupt Arbiter with Vectored Targets

This block decides which interrupt, if any, a processor core should take next, and where the core should jump to handle it. It watches 32 level-sensitive interrupt lines, of which only the software line (ID 3), the timer line (ID 7), the external line (ID 11) and the custom lines (IDs 16 to 31) exist. Each line is qualified by its own enable bit and by a global enable. A non-maskable request with a two-bit cause code outranks every line. While the core is in debug mode, nothing is taken.

The pending image of the implemented lines is driven straight from the inputs, so it is the value a status register would read back. The winner is picked in a fixed order. It is highest ID first, except that the timer line ranks below the software line. Its cause word and jump target are registered together on the cycle the request is seen. The target is the 128-byte aligned trap table base. In vectored mode, 4 times the interrupt ID is added to it. The non-maskable request uses slot 15 of the table.

A two-state machine drives the take request. In ST_IDLE no take is requested. The transition IDLE_TO_TAKE fires on any qualified request, and TAKE_HOLD keeps ST_TAKE while a request is still present. TAKE_TO_IDLE fires when no qualified request remains, and IDLE_HOLD keeps ST_IDLE otherwise.

Top module: `irq_vec_arbiter`

## Requirements
- R1: `pend_o` equals `line_i` with every bit outside {3, 7, 11, 16..31} forced to 0, with no register delay. The block never clears a pending bit; it follows its line.
- R2: A line is a candidate only when its input bit, its `line_en_i` bit and `glb_en_i` are all 1.
- R3: The winning request is chosen in this order, highest first: the non-maskable request, then lines 31 down to 16, then 11, then 3, then 7.
- R4: While `dbg_mode_i` is 1, no request is taken, including the non-maskable one, whatever the enables are.
- R5: `take_o` is 1 in the cycle after the clock edge at which a qualified request was present. It is 0 in the cycle after an edge at which none was present (states ST_IDLE / ST_TAKE).
- R6: `cause_o` bit 31 is 1. Its bits 30:0 hold the winning line ID, or 1024 plus `nmi_code_i` for the non-maskable request.
- R7: When `tvec_mode_i` is not 2'b01 (non-vectored), `target_o` equals `{tvec_base_i, 7'b0}` for any winner.
- R8: When `tvec_mode_i` is 2'b01 (vectored), `target_o` for a line winner equals `{tvec_base_i, 7'b0} + 4*ID`.
- R9: In vectored mode, the non-maskable request targets `{tvec_base_i, 7'b0} + 60` (slot 15).
- R10: After reset, `take_o`, `cause_o` and `target_o` are 0 and the state is ST_IDLE. With all enables at their cleared values, only the non-maskable request can be taken.
- R11: After the edge at which no request is present, `cause_o` and `target_o` keep their last loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 32 | Level-sensitive interrupt lines |
| line_en_i | input | 32 | Per-line enable bits |
| glb_en_i | input | 1 | Global interrupt enable |
| dbg_mode_i | input | 1 | Core is in debug mode |
| nmi_req_i | input | 1 | Non-maskable request, level |
| nmi_code_i | input | 2 | Cause offset of the non-maskable request (added to 1024) |
| tvec_base_i | input | 25 | Trap table base, address bits 31:7 |
| tvec_mode_i | input | 2 | Table mode: 2'b01 vectored, any other value non-vectored |
| pend_o | output | 32 | Pending image of the implemented lines |
| take_o | output | 1 | Request to take an interrupt |
| cause_o | output | 32 | Registered cause word of the winner |
| target_o | output | 32 | Registered jump target of the winner |

## Verification
The bound checker watches these properties on every cycle:
- debug mode always suppresses the take,
- a non-maskable request is always taken with the right cause code,
- a missing global enable blocks every line,
- the pending image never shows a reserved line or a line that is low,
- every non-vectored target is aligned,
- software always beats timer when the two are the only candidates.

Only the directed scenarios can show some other behaviours:
- the full priority ladder across custom, external, software and timer lines,
- the vectored target arithmetic,
- the NMI slot,
- the one-cycle take latency,
- that cause and target are held after the request goes away.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

    // Take state machine encoding
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_TAKE = 1'b1
    } arb_state_e;

    // Mode field value that selects vectored dispatch
    localparam logic [1:0] MODE_VECTORED = 2'b01;

endpackage

// File: rtl/irqarb_mask.sv
module irqarb_mask #(
    parameter int                    NUM_LINES = 32,
    parameter logic [NUM_LINES-1:0]  IMPL_MASK = 32'hFFFF_0888
) (
    input  logic [NUM_LINES-1:0] line_i,
    input  logic [NUM_LINES-1:0] en_i,
    input  logic                 glb_en_i,
    input  logic                 dbg_mode_i,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [NUM_LINES-1:0] elig_o
);

    logic open_gate;

    // Reserved lines read as zero; pending follows the line level.
    assign pend_o    = line_i & IMPL_MASK;
    assign open_gate = glb_en_i & ~dbg_mode_i;
    assign elig_o    = pend_o & en_i & {NUM_LINES{open_gate}};

endmodule

// File: rtl/irqarb_prio.sv
module irqarb_prio #(
    parameter int NUM_LINES = 32,
    parameter int TIMER_ID  = 7,
    parameter bit DEMOTE_TIMER = 1'b1,
    localparam int ID_W = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] elig_i,
    output logic                 win_valid_o,
    output logic [ID_W-1:0]      win_id_o
);

    generate
        if (DEMOTE_TIMER) begin : g_demoted
            logic            main_found;
            logic [ID_W-1:0] main_id;

            // Highest ID wins among all lines except the timer.
            always_comb begin
                main_found = 1'b0;
                main_id    = '0;
                for (int i = 0; i < NUM_LINES; i++) begin
                    if (elig_i[i] && (i != TIMER_ID)) begin
                        main_found = 1'b1;
                        main_id    = ID_W'(i);
                    end
                end
            end

            // Timer only wins when nothing else is eligible.
            always_comb begin
                if (main_found) begin
                    win_valid_o = 1'b1;
                    win_id_o    = main_id;
                end else begin
                    win_valid_o = elig_i[TIMER_ID];
                    win_id_o    = ID_W'(TIMER_ID);
                end
            end
        end else begin : g_plain
            always_comb begin
                win_valid_o = 1'b0;
                win_id_o    = '0;
                for (int i = 0; i < NUM_LINES; i++) begin
                    if (elig_i[i]) begin
                        win_valid_o = 1'b1;
                        win_id_o    = ID_W'(i);
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irqarb_target.sv
module irqarb_target
    import irqarb_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ALIGN_BITS = 7,
    parameter int ID_W       = 5,
    parameter int NMI_SLOT   = 15
) (
    input  logic [XLEN-1:ALIGN_BITS] base_i,
    input  logic [1:0]               mode_i,
    input  logic                     is_nmi_i,
    input  logic [ID_W-1:0]          id_i,
    output logic [XLEN-1:0]          target_o
);

    logic [ID_W-1:0] slot;
    logic [XLEN-1:0] base_addr;
    logic [XLEN-1:0] offset;

    assign slot      = is_nmi_i ? ID_W'(NMI_SLOT) : id_i;
    assign base_addr = {base_i, {ALIGN_BITS{1'b0}}};
    assign offset    = (mode_i == MODE_VECTORED) ? XLEN'({slot, 2'b00}) : '0;
    assign target_o  = base_addr + offset;

endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
    import irqarb_pkg::*;
#(
    parameter int                   NUM_LINES     = 32,
    parameter int                   XLEN          = 32,
    parameter int                   ALIGN_BITS    = 7,
    parameter logic [NUM_LINES-1:0] IMPL_MASK     = 32'hFFFF_0888,
    parameter int                   TIMER_ID      = 7,
    parameter int                   NMI_SLOT      = 15,
    parameter int                   NMI_CODE_W    = 2,
    parameter int                   NMI_BASE_CODE = 1024
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_LINES-1:0]       line_i,
    input  logic [NUM_LINES-1:0]       line_en_i,
    input  logic                       glb_en_i,
    input  logic                       dbg_mode_i,
    input  logic                       nmi_req_i,
    input  logic [NMI_CODE_W-1:0]      nmi_code_i,
    input  logic [XLEN-1:ALIGN_BITS]   tvec_base_i,
    input  logic [1:0]                 tvec_mode_i,
    output logic [NUM_LINES-1:0]       pend_o,
    output logic                       take_o,
    output logic [XLEN-1:0]            cause_o,
    output logic [XLEN-1:0]            target_o
);

    localparam int ID_W = $clog2(NUM_LINES);

    logic [NUM_LINES-1:0] elig;
    logic                 win_valid;
    logic [ID_W-1:0]      win_id;
    logic                 nmi_live;
    logic                 req_valid;
    logic [XLEN-2:0]      code_next;
    logic [XLEN-1:0]      target_next;
    arb_state_e           state_q, state_d;
    logic [XLEN-1:0]      cause_q, target_q;

    irqarb_mask #(
        .NUM_LINES (NUM_LINES),
        .IMPL_MASK (IMPL_MASK)
    ) mask_i (
        .line_i     (line_i),
        .en_i       (line_en_i),
        .glb_en_i   (glb_en_i),
        .dbg_mode_i (dbg_mode_i),
        .pend_o     (pend_o),
        .elig_o     (elig)
    );

    irqarb_prio #(
        .NUM_LINES    (NUM_LINES),
        .TIMER_ID     (TIMER_ID),
        .DEMOTE_TIMER (1'b1)
    ) prio_i (
        .elig_i      (elig),
        .win_valid_o (win_valid),
        .win_id_o    (win_id)
    );

    // Debug mode masks the non-maskable request as well.
    assign nmi_live  = nmi_req_i & ~dbg_mode_i;
    assign req_valid = nmi_live | win_valid;

    assign code_next = nmi_live ? (XLEN-1)'(NMI_BASE_CODE + int'(nmi_code_i))
                                : (XLEN-1)'(win_id);

    irqarb_target #(
        .XLEN       (XLEN),
        .ALIGN_BITS (ALIGN_BITS),
        .ID_W       (ID_W),
        .NMI_SLOT   (NMI_SLOT)
    ) target_i (
        .base_i   (tvec_base_i),
        .mode_i   (tvec_mode_i),
        .is_nmi_i (nmi_live),
        .id_i     (win_id),
        .target_o (target_next)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_TAKE : ST_IDLE; // IDLE_TO_TAKE / IDLE_HOLD
            ST_TAKE: state_d = req_valid ? ST_TAKE : ST_IDLE; // TAKE_HOLD / TAKE_TO_IDLE
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: cause and target load together on a request
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cause_q  <= '0;
            target_q <= '0;
        end else if (req_valid) begin
            cause_q  <= {1'b1, code_next};
            target_q <= target_next;
        end
    end

    assign take_o   = (state_q == ST_TAKE);
    assign cause_o  = cause_q;
    assign target_o = target_q;

endmodule

// File: rtl/irqarb_chk.sv
module irqarb_chk #(
    parameter int                   NUM_LINES  = 32,
    parameter int                   XLEN       = 32,
    parameter int                   ALIGN_BITS = 7,
    parameter logic [NUM_LINES-1:0] IMPL_MASK  = 32'hFFFF_0888,
    parameter int                   TIMER_ID   = 7,
    parameter int                   SW_ID      = 3,
    parameter int                   NMI_CODE_W = 2
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic [NUM_LINES-1:0]  line_i,
    input logic [NUM_LINES-1:0]  line_en_i,
    input logic                  glb_en_i,
    input logic                  dbg_mode_i,
    input logic                  nmi_req_i,
    input logic [NMI_CODE_W-1:0] nmi_code_i,
    input logic [1:0]            tvec_mode_i,
    input logic [NUM_LINES-1:0]  pend_o,
    input logic                  take_o,
    input logic [XLEN-1:0]       cause_o,
    input logic [XLEN-1:0]       target_o
);

    localparam logic [NUM_LINES-1:0] PAIR = (NUM_LINES'(1) << TIMER_ID) | (NUM_LINES'(1) << SW_ID);

    // R4
    dbg_blocks_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_mode_i |=> !take_o);

    // R6
    nmi_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nmi_req_i && !dbg_mode_i) |=>
            (take_o && cause_o == ({1'b1, (XLEN-1)'(0)} | XLEN'(1024) | XLEN'($past(nmi_code_i)))));

    // R2
    glb_off_no_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!glb_en_i && !nmi_req_i) |=> !take_o);

    // R1
    pend_reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pend_o & ~IMPL_MASK) == '0) && ((pend_o & ~line_i) == '0));

    // R7
    nonvec_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_o && $past(tvec_mode_i) != 2'b01) |-> (target_o[ALIGN_BITS-1:0] == '0));

    // R3
    sw_over_timer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (glb_en_i && !dbg_mode_i && !nmi_req_i && ((line_i & line_en_i & IMPL_MASK) == PAIR))
            |=> (take_o && cause_o[XLEN-2:0] == (XLEN-1)'(SW_ID)));

    // R6
    cause_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> cause_o[XLEN-1]);

endmodule

bind irq_vec_arbiter irqarb_chk #(
    .NUM_LINES  (NUM_LINES),
    .XLEN       (XLEN),
    .ALIGN_BITS (ALIGN_BITS),
    .IMPL_MASK  (IMPL_MASK),
    .TIMER_ID   (TIMER_ID),
    .SW_ID      (3),
    .NMI_CODE_W (NMI_CODE_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_i      (line_i),
    .line_en_i   (line_en_i),
    .glb_en_i    (glb_en_i),
    .dbg_mode_i  (dbg_mode_i),
    .nmi_req_i   (nmi_req_i),
    .nmi_code_i  (nmi_code_i),
    .tvec_mode_i (tvec_mode_i),
    .pend_o      (pend_o),
    .take_o      (take_o),
    .cause_o     (cause_o),
    .target_o    (target_o)
);

// File: tb/irq_vec_arbiter_tb_top.sv
module irq_vec_arbiter_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic [31:0] ens = '0;
    logic        glb = 1'b0;
    logic        dbg = 1'b0;
    logic        nmi = 1'b0;
    logic [1:0]  ncode = '0;
    logic [31:0] tbase = '0;
    logic [1:0]  tmode = '0;
    logic [31:0] pend;
    logic        take;
    logic [31:0] cause, target;

    int  n_vec = 0;
    int  n_err = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vec_arbiter dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .line_i      (lines),
        .line_en_i   (ens),
        .glb_en_i    (glb),
        .dbg_mode_i  (dbg),
        .nmi_req_i   (nmi),
        .nmi_code_i  (ncode),
        .tvec_base_i (tbase[31:7]),
        .tvec_mode_i (tmode),
        .pend_o      (pend),
        .take_o      (take),
        .cause_o     (cause),
        .target_o    (target)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Independent reference: returns expected take, cause, target
    task automatic model(output bit e_take, output logic [31:0] e_cause, output logic [31:0] e_tgt);
        logic [31:0] e;
        int slot;
        bit found;
        e_take = 0; e_cause = '0; e_tgt = '0; slot = 0; found = 0;
        e = lines & ens & 32'hFFFF_0888;
        if (!glb) e = '0;
        if (!dbg) begin
            if (nmi) begin
                found = 1; slot = 15; e_cause = 32'h8000_0400 + 32'(ncode);
            end else begin
                for (int i = 31; i >= 16; i--) begin
                    if (!found && e[i]) begin found = 1; slot = i; end
                end
                if (!found && e[11]) begin found = 1; slot = 11; end
                if (!found && e[3])  begin found = 1; slot = 3;  end
                if (!found && e[7])  begin found = 1; slot = 7;  end
                e_cause = 32'h8000_0000 | 32'(slot);
            end
        end
        e_take = found;
        e_tgt  = {tbase[31:7], 7'b0} + ((tmode == 2'b01) ? 32'(slot * 4) : 32'd0);
    endtask

    task automatic drive(input logic [31:0] l, input logic [31:0] en, input bit g, input bit d,
                         input bit n, input logic [1:0] c, input logic [31:0] b, input logic [1:0] m);
        @(negedge clk);
        lines = l; ens = en; glb = g; dbg = d; nmi = n; ncode = c; tbase = b; tmode = m;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Apply one stimulus, wait one edge, compare against the model
    task automatic run_case(input string tag, input logic [31:0] l, input logic [31:0] en,
                            input bit g, input bit d, input bit n, input logic [1:0] c,
                            input logic [31:0] b, input logic [1:0] m);
        bit e_take;
        logic [31:0] e_cause, e_tgt;
        drive(l, en, g, d, n, c, b, m);
        model(e_take, e_cause, e_tgt);
        step();
        chk({tag, " take"}, {31'b0, take}, {31'b0, e_take});
        if (e_take) begin
            chk({tag, " cause"}, cause, e_cause);
            chk({tag, " target"}, target, e_tgt);
        end
    endtask

    task automatic t_reset();
        // R10: reset values
        chk("R10 take", {31'b0, take}, 32'd0);
        chk("R10 cause", cause, 32'd0);
        chk("R10 target", target, 32'd0);
        chk("R10 pend", pend, 32'd0);
        // R10: cleared enables, only NMI can be taken
        run_case("R10 lines only", 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0000_1000, 2'b00);
        run_case("R10 nmi", 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 1'b1, 2'd1, 32'h0000_1000, 2'b00);
    endtask

    task automatic t_pending();
        // R1: reserved lines forced low, no delay
        drive(32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 2'b00);
        #1 chk("R1 all lines", pend, 32'hFFFF_0888);
        drive(32'h0000_F777, 32'h0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 2'b00);
        #1 chk("R1 reserved only", pend, 32'h0);
        drive(32'h0001_0008, 32'h0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 2'b00);
        #1 chk("R1 sparse", pend, 32'h0001_0008);
    endtask

    task automatic t_enable();
        // R2: all three qualifiers needed
        run_case("R2 no glb", 32'h800, 32'h800, 1'b0, 1'b0, 1'b0, 2'd0, 32'h2000, 2'b00);
        run_case("R2 no en", 32'h800, 32'h0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h2000, 2'b00);
        run_case("R2 no line", 32'h0, 32'h800, 1'b1, 1'b0, 1'b0, 2'd0, 32'h2000, 2'b00);
        run_case("R2 all set", 32'h800, 32'h800, 1'b1, 1'b0, 1'b0, 2'd0, 32'h2000, 2'b00);
        run_case("R2 reserved line", 32'h0000_0004, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, 32'h2000, 2'b00);
    endtask

    task automatic t_priority();
        // R3: ladder NMI > 31..16 > 11 > 3 > 7
        run_case("R3 sw over timer", 32'h88, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, 32'h2000, 2'b00);
        run_case("R3 timer alone", 32'h80, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, 32'h2000, 2'b00);
        run_case("R3 ext over sw", 32'h888, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, 32'h2000, 2'b00);
        run_case("R3 custom over ext", 32'h0010_0888, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, 32'h2000, 2'b00);
        run_case("R3 31 over 16", 32'h8001_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, 32'h2000, 2'b00);
        run_case("R3 masked high", 32'h8001_0000, 32'h0001_0000, 1'b1, 1'b0, 1'b0, 2'd0, 32'h2000, 2'b00);
        run_case("R3 nmi over all", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 2'd3, 32'h2000, 2'b00);
    endtask

    task automatic t_debug();
        // R4: debug mode blocks lines and NMI
        run_case("R4 dbg lines", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 2'd0, 32'h2000, 2'b00);
        run_case("R4 dbg nmi", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 2'd2, 32'h2000, 2'b01);
        run_case("R4 after dbg", 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 2'd2, 32'h2000, 2'b01);
    endtask

    task automatic t_latency();
        // R5: take rises one edge after the request, falls one edge after it goes
        drive(32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h3000, 2'b01);
        step();
        drive(32'h0004_0000, 32'h0004_0000, 1'b1, 1'b0, 1'b0, 2'd0, 32'h3000, 2'b01);
        #1 chk("R5 before edge", {31'b0, take}, 32'd0);
        step();
        chk("R5 after edge", {31'b0, take}, 32'd1);
        chk("R6 line cause", cause, 32'h8000_0012);
        step();
        chk("R5 hold", {31'b0, take}, 32'd1);
        chk("R1 not cleared", pend, 32'h0004_0000);
        drive(32'h0, 32'h0004_0000, 1'b1, 1'b0, 1'b0, 2'd0, 32'h5000, 2'b00);
        step();
        chk("R5 drop", {31'b0, take}, 32'd0);
        // R11: values held after request gone, though base/mode changed
        chk("R11 cause held", cause, 32'h8000_0012);
        chk("R11 target held", target, 32'h0000_3048);
    endtask

    task automatic t_target();
        // R8: vectored, base low bits ignored
        run_case("R8 vec line20", 32'h0010_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_20C5, 2'b01);
        chk("R8 vec value", target, 32'h0000_20D0);
        run_case("R8 vec line31", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, 32'hFFFF_FF80, 2'b01);
        chk("R8 vec top", target, 32'hFFFF_FFFC);
        // R7: non-vectored, including mode 3
        run_case("R7 nonvec", 32'h0010_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_20C4, 2'b00);
        chk("R7 nonvec value", target, 32'h0000_2080);
        run_case("R7 mode3", 32'h0000_0800, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_20C7, 2'b11);
        chk("R7 mode3 value", target, 32'h0000_2080);
        // R9: NMI slot 15 in vectored mode, base in non-vectored
        run_case("R9 nmi vec", 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 2'd2, 32'h0000_2080, 2'b01);
        chk("R9 nmi vec value", target, 32'h0000_20BC);
        chk("R6 nmi cause", cause, 32'h8000_0402);
        run_case("R9 nmi nonvec", 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 2'd0, 32'h0000_2080, 2'b00);
        chk("R9 nmi nonvec value", target, 32'h0000_2080);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_pending();
        t_enable();
        t_priority();
        t_debug();
        t_latency();
        t_target();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

endmodule